// File: doc/BRIEF.md
# Command-Driven APB Bus Master

This block turns a stream of commands into bus cycles on a simplified APB bus. The bus has no wait-state or error signals. A command is accepted through a valid/ready handshake. It is one of three operations: a write, a read, or an idle. Each command carries an address, write data, a count of idle cycles to insert after it, and an optional burst request with a length.

A single access always takes exactly two clocks. The first is a setup cycle (select high, enable low) and the second is an enable cycle (select and enable high). The block then leaves the bus idle for the command's idle count and raises a one-cycle done pulse. The usual idle count is 1.

A burst issues back-to-back word accesses from a base address, stepping the address by one word per beat. There is no idle gap between beats, and exactly one idle cycle follows the last beat. Read data is captured in each enable cycle. It is flagged with a per-beat pulse and held on the read data output until the next read.

Top module: `apb_cmd_master`

## Requirements
- R1: Every access is a setup cycle (bus_sel=1, bus_enable=0) followed in the next cycle by an enable cycle (bus_sel=1, bus_enable=1). bus_addr, bus_write and bus_wdata do not change between the two.
- R2: cmd_op 2'b01 is a write: the setup cycle drives bus_addr=cmd_addr, bus_write=1 and bus_wdata=cmd_wdata. cmd_op 2'b10 is a read: it drives bus_write=0 and does not touch bus_wdata, which stays 0 from the preceding idle cycle.
- R3: In an idle cycle bus_sel=0, bus_enable=0 and bus_wdata=0, while bus_addr and bus_write keep the values of the last access.
- R4: After the enable cycle of a single access, exactly cmd_idles idle cycles follow. In the next cycle done=1 and cmd_ready=1. With cmd_idles=0, done rises in the cycle right after the enable cycle.
- R5: For a read, bus_rdata is captured at the end of the enable cycle. In the following cycle rd_valid=1 and rd_data shows the captured word. rd_data holds it through done and until the next read.
- R6: With cmd_burst=1, beat i uses address cmd_addr + 4*i, wrapping modulo 2^32. Each setup cycle follows the previous enable cycle directly. Exactly one idle cycle follows the last beat, whatever cmd_idles is.
- R7: The burst length cmd_len (6 bits) gives the beat count. A value of 0 runs one beat, and values above 32 run 32 beats.
- R8: Every beat of a write burst drives cmd_wdata; every beat of a read burst raises its own rd_valid pulse.
- R9: While rst_n is low, bus_addr, bus_write, bus_sel, bus_enable, bus_wdata, rd_valid, rd_data and done are all 0.
- R10: cmd_ready is 1 only when no access or idle cycle is pending. It stays 0 from acceptance through the whole burst or access and its idle cycles. cmd_valid has no effect while cmd_ready is 0.
- R11: done is high for exactly one cycle per command.
- R12: cmd_op 2'b00 (and 2'b11) is an idle command: the bus stays idle for cmd_idles cycles, then done rises. A count of 0 raises done in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted on a clock edge when both are high |
| cmd_op | input | 2 | 00 idle, 01 write, 10 read, 11 idle |
| cmd_addr | input | 32 | Address, or base address of a burst |
| cmd_wdata | input | 32 | Write data (every beat of a write burst) |
| cmd_idles | input | 8 | Idle cycles after a single access or idle command |
| cmd_burst | input | 1 | Run a burst of cmd_len beats |
| cmd_len | input | 6 | Burst beat count (0 means 1, above 32 means 32) |
| bus_addr | output | 32 | Bus address |
| bus_write | output | 1 | Bus direction, 1 = write |
| bus_sel | output | 1 | Bus select |
| bus_enable | output | 1 | Bus enable phase |
| bus_wdata | output | 32 | Bus write data |
| bus_rdata | input | 32 | Bus read data from the slave |
| rd_valid | output | 1 | One-cycle pulse per captured read beat |
| rd_data | output | 32 | Last captured read word |
| done | output | 1 | One-cycle command completion pulse |

## Verification
The assertions check the bus protocol on every cycle:
- a setup cycle is always followed by an enable cycle;
- address, direction and data stay stable into the enable cycle, and address and direction are held through idle cycles;
- consecutive burst beats step the address by one word;
- cmd_ready is seen only on an idle bus, and done is a single pulse seen only with cmd_ready.

Only the bench scenarios can show the counted behaviour. That covers the exact number of idle cycles per command, the clamped burst lengths, the wrapped burst addresses and the captured read values. It also covers the fact that a command offered while busy leaves the running burst unchanged.

// File: rtl/apbm_pkg.sv
package apbm_pkg;

  // Command operation codes carried on cmd_op.
  localparam logic [1:0] OP_IDLE  = 2'b00;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;

  // Sequencer phases.
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_ENABLE = 2'd2,
    ST_GAP    = 2'd3
  } seq_state_e;

endpackage

// File: rtl/apbm_ctrl.sv
module apbm_ctrl
  import apbm_pkg::*;
#(
  parameter int IDLE_W    = 8,
  parameter int LEN_W     = 6,
  parameter int MAX_BEATS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [IDLE_W-1:0] cmd_idles,
  input  logic              cmd_burst,
  input  logic [LEN_W-1:0]  cmd_len,
  output logic              cmd_ready,
  output logic              go_first,
  output logic              first_write,
  output logic              go_next,
  output logic              go_enable,
  output logic              cap_en,
  output logic              done
);

  localparam int CNT_W = $clog2(MAX_BEATS + 1);

  seq_state_e        state_q;
  logic              wr_q;
  logic              burst_q;
  logic [CNT_W-1:0]  beats_q;
  logic [IDLE_W-1:0] idles_q;
  logic [IDLE_W-1:0] gap_q;
  logic              done_q;

  logic              accept;
  logic              is_xfer;
  logic              last_beat;
  logic [IDLE_W-1:0] gap_after;

  // Effective beat count: single access is one beat, burst length clamped.
  function automatic logic [CNT_W-1:0] beats_of(input logic burst,
                                                input logic [LEN_W-1:0] len);
    if (!burst || len == '0)
      return CNT_W'(1);
    else if (int'(len) > MAX_BEATS)
      return CNT_W'(MAX_BEATS);
    else
      return CNT_W'(len);
  endfunction

  assign cmd_ready   = (state_q == ST_IDLE);
  assign accept      = cmd_valid && cmd_ready;
  assign is_xfer     = (cmd_op == OP_WRITE) || (cmd_op == OP_READ);
  assign first_write = (cmd_op == OP_WRITE);
  assign go_first    = accept && is_xfer;
  assign go_enable   = (state_q == ST_SETUP);
  assign last_beat   = (beats_q == CNT_W'(1));
  assign go_next     = (state_q == ST_ENABLE) && burst_q && !last_beat;
  assign cap_en      = (state_q == ST_ENABLE) && !wr_q;
  assign gap_after   = burst_q ? IDLE_W'(1) : idles_q;
  assign done        = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wr_q    <= 1'b0;
      burst_q <= 1'b0;
      beats_q <= '0;
      idles_q <= '0;
      gap_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            if (is_xfer) begin
              state_q <= ST_SETUP;
              wr_q    <= first_write;
              burst_q <= cmd_burst;
              beats_q <= beats_of(cmd_burst, cmd_len);
              idles_q <= cmd_idles;
            end else if (cmd_idles == '0) begin
              done_q <= 1'b1;
            end else begin
              state_q <= ST_GAP;
              gap_q   <= cmd_idles;
            end
          end
        end
        ST_SETUP: begin
          state_q <= ST_ENABLE;
        end
        ST_ENABLE: begin
          if (go_next) begin
            state_q <= ST_SETUP;
            beats_q <= beats_q - CNT_W'(1);
          end else if (gap_after == '0) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            state_q <= ST_GAP;
            gap_q   <= gap_after;
          end
        end
        ST_GAP: begin
          if (gap_q == IDLE_W'(1)) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            gap_q <= gap_q - IDLE_W'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/apbm_bus.sv
module apbm_bus #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_first,
  input  logic              first_write,
  input  logic              go_next,
  input  logic              go_enable,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_write,
  output logic              bus_sel,
  output logic              bus_enable,
  output logic [DATA_W-1:0] bus_wdata
);

  localparam int STEP = DATA_W / 8;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_addr   <= '0;
      bus_write  <= 1'b0;
      bus_sel    <= 1'b0;
      bus_enable <= 1'b0;
      bus_wdata  <= '0;
    end else if (go_first) begin
      bus_addr   <= cmd_addr;
      bus_write  <= first_write;
      bus_sel    <= 1'b1;
      bus_enable <= 1'b0;
      if (first_write)
        bus_wdata <= cmd_wdata;
    end else if (go_next) begin
      // Next burst beat: word step, data and direction carried over.
      bus_addr   <= bus_addr + ADDR_W'(STEP);
      bus_sel    <= 1'b1;
      bus_enable <= 1'b0;
    end else if (go_enable) begin
      bus_enable <= 1'b1;
    end else begin
      // Idle: address and direction held to avoid toggling.
      bus_sel    <= 1'b0;
      bus_enable <= 1'b0;
      bus_wdata  <= '0;
    end
  end

endmodule

// File: rtl/apbm_rcap.sv
module apbm_rcap #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= cap_en;
      if (cap_en)
        rd_data <= bus_rdata;
    end
  end

endmodule

// File: rtl/apb_cmd_master.sv
module apb_cmd_master #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int IDLE_W    = 8,
  parameter int LEN_W     = 6,
  parameter int MAX_BEATS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic [IDLE_W-1:0] cmd_idles,
  input  logic              cmd_burst,
  input  logic [LEN_W-1:0]  cmd_len,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_write,
  output logic              bus_sel,
  output logic              bus_enable,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              done
);

  logic go_first;
  logic first_write;
  logic go_next;
  logic go_enable;
  logic cap_en;

  apbm_ctrl #(
    .IDLE_W    (IDLE_W),
    .LEN_W     (LEN_W),
    .MAX_BEATS (MAX_BEATS)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_op      (cmd_op),
    .cmd_idles   (cmd_idles),
    .cmd_burst   (cmd_burst),
    .cmd_len     (cmd_len),
    .cmd_ready   (cmd_ready),
    .go_first    (go_first),
    .first_write (first_write),
    .go_next     (go_next),
    .go_enable   (go_enable),
    .cap_en      (cap_en),
    .done        (done)
  );

  apbm_bus #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_bus (
    .clk         (clk),
    .rst_n       (rst_n),
    .go_first    (go_first),
    .first_write (first_write),
    .go_next     (go_next),
    .go_enable   (go_enable),
    .cmd_addr    (cmd_addr),
    .cmd_wdata   (cmd_wdata),
    .bus_addr    (bus_addr),
    .bus_write   (bus_write),
    .bus_sel     (bus_sel),
    .bus_enable  (bus_enable),
    .bus_wdata   (bus_wdata)
  );

  apbm_rcap #(
    .DATA_W (DATA_W)
  ) u_rcap (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_en    (cap_en),
    .bus_rdata (bus_rdata),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data)
  );

endmodule

// File: rtl/apbm_chk.sv
module apbm_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_ready,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_write,
  input logic              bus_sel,
  input logic              bus_enable,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              rd_valid,
  input logic              done
);

  localparam int STEP = DATA_W / 8;

  assert_setup_then_enable_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_enable) |=> (bus_sel && bus_enable));

  assert_enable_stable_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_enable) |-> ($stable(bus_addr) && $stable(bus_write) && $stable(bus_wdata)));

  assert_read_no_wdata_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_write) |-> (bus_wdata == '0));

  assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel |-> (!bus_enable && bus_wdata == '0));

  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel |-> ($stable(bus_addr) && $stable(bus_write)));

  assert_done_with_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cmd_ready && !bus_sel));

  assert_capture_in_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(bus_sel && bus_enable && !bus_write));

  assert_burst_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_enable && $past(bus_sel && bus_enable))
      |-> (bus_addr == $past(bus_addr) + ADDR_W'(STEP)));

  assert_ready_on_idle_bus_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !bus_sel);

  assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

bind apb_cmd_master apbm_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_ready  (cmd_ready),
  .bus_addr   (bus_addr),
  .bus_write  (bus_write),
  .bus_sel    (bus_sel),
  .bus_enable (bus_enable),
  .bus_wdata  (bus_wdata),
  .rd_valid   (rd_valid),
  .done       (done)
);

// File: tb/sim_apb_cmd_master.sv
module sim_apb_cmd_master;

  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [1:0]  cmd_op = 2'b00;
  logic [31:0] cmd_addr = '0;
  logic [31:0] cmd_wdata = '0;
  logic [7:0]  cmd_idles = '0;
  logic        cmd_burst = 1'b0;
  logic [5:0]  cmd_len = '0;
  logic [31:0] bus_addr;
  logic        bus_write;
  logic        bus_sel;
  logic        bus_enable;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic        done;

  int          n_checks = 0;
  int          n_errors = 0;
  bit          finished = 1'b0;
  logic [31:0] last_addr = '0;
  logic        last_write = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  apb_cmd_master u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .cmd_idles(cmd_idles), .cmd_burst(cmd_burst), .cmd_len(cmd_len),
    .bus_addr(bus_addr), .bus_write(bus_write), .bus_sel(bus_sel),
    .bus_enable(bus_enable), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .done(done)
  );

  // Slave model: address-derived word in the enable cycle, junk otherwise.
  function automatic logic [31:0] slave_word(input logic [31:0] a);
    return {a[15:0], ~a[31:16]} ^ 32'h3C5A_0F96;
  endfunction

  assign bus_rdata = (bus_sel && bus_enable) ? slave_word(bus_addr) : 32'hDEAD_BEEF;

  function automatic int exp_beats(input bit burst, input int len);
    if (!burst || len == 0) return 1;
    if (len > 32) return 32;
    return len;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  // Issue one command and follow it cycle by cycle to its done pulse.
  task automatic run_cmd(input logic [1:0] op, input logic [31:0] addr,
                         input logic [31:0] wdata, input int idles,
                         input bit burst, input int len, input bit spam);
    bit          xfer;
    bit          wr;
    int          nb;
    int          gaps;
    logic [31:0] a;
    xfer = (op == 2'b01) || (op == 2'b10);
    wr   = (op == 2'b01);
    @(negedge clk);
    chk("R11", "done low before issue", {31'd0, done}, 32'd0);
    chk("R10", "ready before issue", {31'd0, cmd_ready}, 32'd1);
    cmd_op = op; cmd_addr = addr; cmd_wdata = wdata;
    cmd_idles = 8'(idles); cmd_burst = burst; cmd_len = 6'(len);
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = spam;
    if (spam) begin
      cmd_op = 2'b01; cmd_addr = ~addr; cmd_wdata = ~wdata; cmd_burst = 1'b0;
    end
    if (xfer) begin
      nb = exp_beats(burst, len);
      for (int b = 0; b < nb; b++) begin
        a = addr + 32'(4 * b);
        chk("R1", "setup sel/en", {30'd0, bus_sel, bus_enable}, 32'd2);
        chk("R6", "beat address", bus_addr, a);
        chk("R2", "direction", {31'd0, bus_write}, {31'd0, wr});
        chk("R8", "setup wdata", bus_wdata, wr ? wdata : 32'd0);
        chk("R10", "ready low in setup", {31'd0, cmd_ready}, 32'd0);
        @(negedge clk);
        chk("R1", "enable sel/en", {30'd0, bus_sel, bus_enable}, 32'd3);
        chk("R1", "enable address", bus_addr, a);
        chk("R1", "enable wdata", bus_wdata, wr ? wdata : 32'd0);
        @(negedge clk);
        if (b == nb - 1) cmd_valid = 1'b0;
        chk("R8", "read beat pulse", {31'd0, rd_valid}, {31'd0, !wr});
        if (!wr) chk("R5", "captured word", rd_data, slave_word(a));
        if (b < nb - 1)
          chk("R6", "no gap between beats", {31'd0, bus_sel}, 32'd1);
      end
      last_addr  = addr + 32'(4 * (nb - 1));
      last_write = wr;
      gaps = burst ? 1 : idles;
    end else begin
      gaps = idles;
    end
    cmd_valid = 1'b0;
    for (int g = 0; g < gaps; g++) begin
      chk(xfer ? "R3" : "R12", "idle sel/en", {30'd0, bus_sel, bus_enable}, 32'd0);
      chk("R3", "idle wdata zero", bus_wdata, 32'd0);
      chk("R3", "idle addr held", bus_addr, last_addr);
      chk("R3", "idle dir held", {31'd0, bus_write}, {31'd0, last_write});
      chk(burst && xfer ? "R6" : "R4", "no early done", {31'd0, done}, 32'd0);
      chk("R10", "ready low in gap", {31'd0, cmd_ready}, 32'd0);
      @(negedge clk);
    end
    chk(xfer ? "R4" : "R12", "done pulse", {31'd0, done}, 32'd1);
    chk("R4", "ready with done", {31'd0, cmd_ready}, 32'd1);
    chk("R3", "bus idle at done", {31'd0, bus_sel}, 32'd0);
    if (xfer && !wr) chk("R5", "read data held at done", rd_data, slave_word(last_addr));
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    // R9: outputs zero while in reset
    chk("R9", "addr in reset", bus_addr, 32'd0);
    chk("R9", "ctl in reset", {27'd0, bus_write, bus_sel, bus_enable, rd_valid, done}, 32'd0);
    chk("R9", "wdata in reset", bus_wdata, 32'd0);
    chk("R9", "rdata in reset", rd_data, 32'd0);
    rst_n = 1'b1;

    // Directed cases
    run_cmd(2'b01, 32'h0000_1000, 32'hCAFE_0001, 1, 0, 0, 0);  // R2 write, default gap
    run_cmd(2'b10, 32'h0000_1000, 32'h0,         0, 0, 0, 0);  // R5 read, no gap
    run_cmd(2'b01, 32'h0000_2004, 32'h1234_5678, 3, 0, 0, 0);  // R4 three gaps
    run_cmd(2'b00, 32'h0,         32'h0,         0, 0, 0, 0);  // R12 zero idle command
    run_cmd(2'b00, 32'hFFFF_0000, 32'h0,         2, 0, 0, 0);  // R12 two idles, addr held
    run_cmd(2'b01, 32'h0000_3000, 32'hA0A0_0505, 5, 1, 0, 0);  // R7 len 0 -> 1 beat
    run_cmd(2'b01, 32'h0000_4000, 32'h7777_8888, 0, 1, 4, 0);  // R8 write burst
    run_cmd(2'b10, 32'h0000_5000, 32'h0,         7, 1, 32, 0); // R6 read burst 32
    run_cmd(2'b10, 32'h0000_6000, 32'h0,         0, 1, 45, 0); // R7 clamp to 32
    run_cmd(2'b10, 32'hFFFF_FFF8, 32'h0,         0, 1, 4, 0);  // R6 address wrap
    run_cmd(2'b01, 32'h0000_7000, 32'h5555_AAAA, 2, 1, 3, 1);  // R10 offers while busy
    run_cmd(2'b11, 32'h0,         32'h0,         1, 0, 0, 0);  // R12 code 11 is idle

    // Constrained random mix
    for (int i = 0; i < 60; i++) begin
      logic [1:0] op;
      int r;
      r  = int'($urandom % 8);
      op = (r < 3) ? 2'b01 : (r < 6) ? 2'b10 : 2'b00;
      run_cmd(op, {$urandom, 2'b00} , $urandom, int'($urandom % 4),
              ($urandom % 3) == 0, int'($urandom % 64), ($urandom % 4) == 0);
    end
    finish_run();
  end

  initial begin
    #(PERIOD * 150000);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

endmodule